// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the transmit side of a network DMA engine. It walks a list of transmit descriptors in host memory, starting at a base address that software supplies. Each descriptor it owns is processed the same way: it reads up to two data buffers byte by byte, streams the bytes to the MAC over a ready/valid byte stream, and writes the flags word back with the ownership bit cleared and the MAC's completion status merged in. A descriptor is four 32-bit words: flags, sizes, buffer 1 address and buffer 2 address. Descriptors sit `DESC_BYTES` apart unless they are chained. The frame-level control bits (CRC append, CRC replace, pad disable) and a start-of-frame marker travel beside each byte. The MAC computes CRC and checksums itself; this block only forwards the requests.

The engine runs while `start_i` is high. It suspends when it finds a descriptor that software still owns, and a one-cycle `poll_i` pulse makes it read that descriptor again. If `start_i` falls, the engine stops after the current write-back. The next time it leaves the stopped state it reloads the descriptor pointer from `desc_base_i`. Memory is reached through a word-addressed port with a grant handshake. A read returns data one or more cycles after its grant, and at most one read is outstanding at a time.

Top module: `txd_ring_engine`

## Requirements
- R1: While reset is held, `tx_tvalid_o`, `mem_req_o` and `irq_o` are low.
- R2: When flags bit 31 (ownership) of a fetched descriptor is 0, the engine enters a suspended state. In that state it streams no byte and makes no memory request, reads included.
- R3: Buffer 1 holds sizes[12:0] bytes and is streamed first, followed by sizes[28:16] bytes of buffer 2. Buffer addresses are byte addresses of any alignment. Bytes within a memory word go out least significant first. A buffer whose size is zero is skipped.
- R4: When flags bit 20 is set, the buffer 2 word is the byte address of the next descriptor. No data is taken from buffer 2, and its size field is ignored.
- R5: When flags bit 21 is set and bit 20 is clear, the next descriptor is read at the base address. When both are clear, it is read at the current address plus `DESC_BYTES`.
- R6: `tx_tlast_o` marks the final byte of a descriptor that has flags bit 29 (last segment) set, and no other byte. `tx_ctrl_o[3]` marks the first byte of a descriptor that has flags bit 28 (first segment) set, and no other byte.
- R7: On every byte of a descriptor, `tx_ctrl_o[0]` equals flags bit 25 (CRC append), `tx_ctrl_o[1]` equals bit 24 (CRC replace) and `tx_ctrl_o[2]` equals bit 26 (pad disable).
- R8: For a last-segment descriptor, the engine waits for `mac_done_i` and then writes the flags word back. The written word has bit 31 cleared. Status bits are `mac_status_i[3:0]` in bits 3:0 (underflow, jabber, local fault, remote fault) and `mac_status_i[4]` (flushed) in bit 5. Bit 15 is the OR of those five. All other bits are unchanged. Other descriptors are written back at once with zero status.
- R9: `irq_o` pulses for one cycle after the write-back of each descriptor that has flags bit 30 set.
- R10: A one-cycle `poll_i` pulse makes a suspended engine fetch the same descriptor again.
- R11: When `start_i` is low, the engine stops after the write-back in progress and also leaves the suspended state. When it leaves the stopped state, it loads its pointer from `desc_base_i`.
- R12: While `tx_tvalid_o` is high and `tx_tready_i` is low, `tx_tvalid_o`, `tx_tdata_o` and `tx_tlast_o` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Engine run enable |
| poll_i | input | 1 | Poll demand pulse, resumes a suspended engine |
| desc_base_i | input | ADDR_W | Byte address of the first descriptor |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | ADDR_W-2 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_gnt_i | input | 1 | Memory request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| tx_tdata_o | output | 8 | Frame byte |
| tx_tvalid_o | output | 1 | Byte valid |
| tx_tready_i | input | 1 | MAC ready for a byte |
| tx_tlast_o | output | 1 | Final byte of the frame |
| tx_ctrl_o | output | 4 | {start of frame, pad disable, CRC replace, CRC append} |
| mac_done_i | input | 1 | MAC completion pulse for the frame |
| mac_status_i | input | 5 | {flushed, remote fault, local fault, jabber, underflow} |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
Assertions are evaluated on every cycle. They check that a stalled byte holds steady, that every write-back clears ownership and carries a consistent error summary, that the end-of-frame mark appears only for last-segment descriptors, that an interrupt follows an accepted write, and that a suspended engine stays quiet. Some behaviour can only be shown by bench scenarios under random grant and ready stalls: the exact byte stream across unaligned single- and two-buffer descriptors, chained links, the ring wrap to the base, the poll-driven resume and the pointer reload after a stop.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int LEN_W  = 13;
  localparam int ST_N   = 5;
  // flags word bit positions
  localparam int OWN_B  = 31;
  localparam int INT_B  = 30;
  localparam int LS_B   = 29;
  localparam int FS_B   = 28;
  localparam int PAD_B  = 26;
  localparam int CAPP_B = 25;
  localparam int CREP_B = 24;
  localparam int EOR_B  = 21;
  localparam int CHN_B  = 20;
  localparam int ESUM_B = 15;

  typedef enum logic [2:0] {
    ST_STOP, ST_RD_REQ, ST_RD_WAIT, ST_SUSP, ST_BUF1, ST_BUF2, ST_MAC, ST_WB
  } eng_st_e;
endpackage

// File: rtl/txd_wb_pack.sv
module txd_wb_pack
  import txd_pkg::*;
(
  input  logic [31:0]     flags_i,
  input  logic [ST_N-1:0] stat_i,
  output logic [31:0]     word_o
);
  always_comb begin
    word_o         = flags_i;
    word_o[OWN_B]  = 1'b0;
    word_o[3:0]    = stat_i[3:0];
    word_o[5]      = stat_i[4];
    word_o[ESUM_B] = |stat_i;
  end
endmodule

// File: rtl/txd_next_ptr.sv
module txd_next_ptr
  import txd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 32
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [31:0]       flags_i,
  input  logic [ADDR_W-1:0] link_i,
  output logic [ADDR_W-1:0] nxt_o
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(DESC_BYTES);

  always_comb begin
    if (flags_i[CHN_B])      nxt_o = link_i;
    else if (flags_i[EOR_B]) nxt_o = base_i;
    else                     nxt_o = cur_i + STRIDE;
  end
endmodule

// File: rtl/txd_byte_streamer.sv
module txd_byte_streamer
  import txd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              last_i,
  input  logic              sof_i,
  input  logic [2:0]        ctrl_i,
  output logic              done_o,
  output logic              mem_req_o,
  output logic [ADDR_W-3:0] mem_addr_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic [7:0]        tdata_o,
  output logic              tvalid_o,
  input  logic              tready_i,
  output logic              tlast_o,
  output logic [3:0]        tctrl_o
);
  localparam int WA_W = ADDR_W - 2;

  logic             busy_q, pend_q, have_q, last_q, sof_q;
  logic [WA_W-1:0]  wptr_q;
  logic [1:0]       bidx_q;
  logic [LEN_W-1:0] rem_q;
  logic [2:0]       ctrl_q;
  logic [31:0]      word_q;
  logic             beat, fin;

  assign beat      = have_q & tready_i;
  assign fin       = beat & (rem_q == LEN_W'(1));
  assign done_o    = fin;
  assign mem_req_o = busy_q & ~have_q & ~pend_q;
  assign mem_addr_o = wptr_q;
  assign tvalid_o  = have_q;
  assign tdata_o   = word_q[8*bidx_q +: 8];
  assign tlast_o   = have_q & last_q & (rem_q == LEN_W'(1));
  assign tctrl_o   = {sof_q, ctrl_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; pend_q <= 1'b0; have_q <= 1'b0;
      last_q <= 1'b0; sof_q  <= 1'b0; ctrl_q <= '0;
      wptr_q <= '0;   bidx_q <= '0;   rem_q  <= '0;
      word_q <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1; pend_q <= 1'b0; have_q <= 1'b0;
      wptr_q <= addr_i[ADDR_W-1:2];
      bidx_q <= addr_i[1:0];
      rem_q  <= len_i;
      last_q <= last_i;
      sof_q  <= sof_i;
      ctrl_q <= ctrl_i;
    end else begin
      if (mem_req_o && mem_gnt_i) pend_q <= 1'b1;
      if (pend_q && mem_rvalid_i) begin
        word_q <= mem_rdata_i;
        have_q <= 1'b1;
        pend_q <= 1'b0;
      end
      if (beat) begin
        rem_q  <= rem_q - LEN_W'(1);
        bidx_q <= bidx_q + 2'd1;
        sof_q  <= 1'b0;
        if (fin) begin
          busy_q <= 1'b0;
          have_q <= 1'b0;
        end else if (bidx_q == 2'd3) begin
          have_q <= 1'b0;
          wptr_q <= wptr_q + WA_W'(1);
        end
      end
    end
  end

  assert_hold_beat_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tvalid_o && !tready_i |=> tvalid_o && $stable(tdata_o) && $stable(tlast_o));

endmodule

// File: rtl/txd_ring_engine.sv
module txd_ring_engine
  import txd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              poll_i,
  input  logic [ADDR_W-1:0] desc_base_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-3:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic [7:0]        tx_tdata_o,
  output logic              tx_tvalid_o,
  input  logic              tx_tready_i,
  output logic              tx_tlast_o,
  output logic [3:0]        tx_ctrl_o,
  input  logic              mac_done_i,
  input  logic [ST_N-1:0]   mac_status_i,
  output logic              irq_o
);
  localparam int WA_W = ADDR_W - 2;

  eng_st_e           state_q, state_d, post_st;
  logic [ADDR_W-1:0] cur_q, nxt_ptr;
  logic [1:0]        widx_q;
  logic [31:0]       flg_q, size_q, b1_q, b2_q, wb_word;
  logic [ST_N-1:0]   stat_q;
  logic              irq_q;
  logic [LEN_W-1:0]  len1, len2;

  logic              ld, ld_last, ld_sof;
  logic [ADDR_W-1:0] ld_addr;
  logic [LEN_W-1:0]  ld_len;
  logic              str_done, str_req;
  logic [WA_W-1:0]   str_addr;
  logic              top_req;
  logic [WA_W-1:0]   top_addr;

  assign len1    = size_q[LEN_W-1:0];
  assign len2    = flg_q[CHN_B] ? '0 : size_q[16 +: LEN_W];
  assign post_st = flg_q[LS_B] ? ST_MAC : ST_WB;

  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    ld_addr = b1_q[ADDR_W-1:0];
    ld_len  = len1;
    ld_last = 1'b0;
    ld_sof  = 1'b0;
    unique case (state_q)
      ST_STOP:   if (start_i) state_d = ST_RD_REQ;
      ST_RD_REQ: if (mem_gnt_i) state_d = ST_RD_WAIT;
      ST_RD_WAIT: if (mem_rvalid_i) begin
        if (widx_q == 2'd0 && !mem_rdata_i[OWN_B]) begin
          state_d = ST_SUSP;
        end else if (widx_q == 2'd3) begin
          if (len1 != '0) begin
            ld      = 1'b1;
            ld_last = flg_q[LS_B] && (len2 == '0);
            ld_sof  = flg_q[FS_B];
            state_d = ST_BUF1;
          end else if (len2 != '0) begin
            ld      = 1'b1;
            ld_addr = mem_rdata_i[ADDR_W-1:0];
            ld_len  = len2;
            ld_last = flg_q[LS_B];
            ld_sof  = flg_q[FS_B];
            state_d = ST_BUF2;
          end else begin
            state_d = post_st;
          end
        end else begin
          state_d = ST_RD_REQ;
        end
      end
      ST_SUSP: begin
        if (!start_i)    state_d = ST_STOP;
        else if (poll_i) state_d = ST_RD_REQ;
      end
      ST_BUF1: if (str_done) begin
        if (len2 != '0) begin
          ld      = 1'b1;
          ld_addr = b2_q[ADDR_W-1:0];
          ld_len  = len2;
          ld_last = flg_q[LS_B];
          state_d = ST_BUF2;
        end else begin
          state_d = post_st;
        end
      end
      ST_BUF2: if (str_done) state_d = post_st;
      ST_MAC:  if (mac_done_i) state_d = ST_WB;
      ST_WB:   if (mem_gnt_i) state_d = start_i ? ST_RD_REQ : ST_STOP;
      default: state_d = ST_STOP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_STOP;
      cur_q   <= '0;
      widx_q  <= '0;
      flg_q   <= '0;
      size_q  <= '0;
      b1_q    <= '0;
      b2_q    <= '0;
      stat_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= 1'b0;
      unique case (state_q)
        ST_STOP: if (start_i) begin
          cur_q  <= desc_base_i;
          widx_q <= '0;
        end
        ST_RD_WAIT: if (mem_rvalid_i) begin
          unique case (widx_q)
            2'd0:    flg_q  <= mem_rdata_i;
            2'd1:    size_q <= mem_rdata_i;
            2'd2:    b1_q   <= mem_rdata_i;
            default: b2_q   <= mem_rdata_i;
          endcase
          widx_q <= (state_d == ST_RD_REQ) ? widx_q + 2'd1 : 2'd0;
          stat_q <= '0;
        end
        ST_MAC: if (mac_done_i) stat_q <= mac_status_i;
        ST_WB: if (mem_gnt_i) begin
          cur_q <= nxt_ptr;
          irq_q <= flg_q[INT_B];
        end
        default: ;
      endcase
    end
  end

  txd_wb_pack u_pack (
    .flags_i (flg_q),
    .stat_i  (stat_q),
    .word_o  (wb_word)
  );

  txd_next_ptr #(.ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES)) u_next (
    .cur_i   (cur_q),
    .base_i  (desc_base_i),
    .flags_i (flg_q),
    .link_i  (b2_q[ADDR_W-1:0]),
    .nxt_o   (nxt_ptr)
  );

  txd_byte_streamer #(.ADDR_W(ADDR_W)) u_str (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (ld),
    .addr_i       (ld_addr),
    .len_i        (ld_len),
    .last_i       (ld_last),
    .sof_i        (ld_sof),
    .ctrl_i       ({flg_q[PAD_B], flg_q[CREP_B], flg_q[CAPP_B]}),
    .done_o       (str_done),
    .mem_req_o    (str_req),
    .mem_addr_o   (str_addr),
    .mem_gnt_i    (mem_gnt_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .tdata_o      (tx_tdata_o),
    .tvalid_o     (tx_tvalid_o),
    .tready_i     (tx_tready_i),
    .tlast_o      (tx_tlast_o),
    .tctrl_o      (tx_ctrl_o)
  );

  assign top_req     = (state_q == ST_RD_REQ) || (state_q == ST_WB);
  assign top_addr    = (state_q == ST_RD_REQ) ? cur_q[ADDR_W-1:2] + WA_W'(widx_q)
                                              : cur_q[ADDR_W-1:2];
  assign mem_req_o   = top_req | str_req;
  assign mem_we_o    = (state_q == ST_WB);
  assign mem_addr_o  = top_req ? top_addr : str_addr;
  assign mem_wdata_o = wb_word;
  assign irq_o       = irq_q;

  assert_own_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> !mem_wdata_o[OWN_B]);

  assert_err_summary_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o[ESUM_B] == |{mem_wdata_o[5], mem_wdata_o[3:0]});

  assert_tlast_last_seg_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_tvalid_o && tx_tlast_o |-> flg_q[LS_B]);

  assert_irq_after_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(mem_req_o && mem_we_o && mem_gnt_i));

  assert_suspend_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_SUSP |-> !mem_req_o && !tx_tvalid_o);

endmodule

// File: tb/sim_txd_ring_engine.sv
module sim_txd_ring_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, poll = 1'b0;
  logic [31:0] base = '0;
  logic        mem_req, mem_we, mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic [7:0]  tdata;
  logic        tvalid, tready = 1'b0, tlast;
  logic [3:0]  tctrl;
  logic        mac_done = 1'b0;
  logic [4:0]  mac_status = '0;
  logic        irq;

  always #5 clk = ~clk;

  txd_ring_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .poll_i(poll), .desc_base_i(base),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .tx_tdata_o(tdata), .tx_tvalid_o(tvalid), .tx_tready_i(tready), .tx_tlast_o(tlast),
    .tx_ctrl_o(tctrl), .mac_done_i(mac_done), .mac_status_i(mac_status), .irq_o(irq)
  );

  logic [31:0] mem [0:4095];
  logic [12:0] exp_q[$];
  logic [4:0]  st_q[$];
  int          wba_q[$];
  logic [31:0] wbv_q[$];
  int errors = 0, checks = 0;
  int wb_cnt = 0, irq_cnt = 0, exp_irq = 0;
  logic        rd_pend = 1'b0;
  logic [29:0] rd_addr = '0;
  logic        mac_arm = 1'b0;
  int          mac_cnt = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wb_exp(input logic [31:0] f, input logic [4:0] st);
    logic [31:0] r;
    r = f & ~32'h8000_802F;
    r[3:0] = st[3:0];
    r[5] = st[4];
    r[15] = |st;
    return r;
  endfunction

  task automatic put_byte(input int a, input logic [7:0] b);
    mem[a >> 2][8*(a % 4) +: 8] = b;
  endtask

  task automatic add_desc(input int da, input logic [31:0] flg, input int l1, input int a1,
                          input int l2, input int a2, input logic [4:0] st);
    bit ls, sof, chn;
    logic [2:0] c;
    logic [7:0] b;
    ls = flg[29]; sof = flg[28]; chn = flg[20];
    c = {flg[26], flg[24], flg[25]};
    mem[da >> 2]       = flg;
    mem[(da >> 2) + 1] = {3'b0, 13'(l2), 3'b0, 13'(l1)};
    mem[(da >> 2) + 2] = 32'(a1);
    mem[(da >> 2) + 3] = 32'(a2);
    for (int i = 0; i < l1; i++) begin
      b = 8'($urandom);
      put_byte(a1 + i, b);
      exp_q.push_back({ls && (i == l1 - 1) && (chn || l2 == 0), sof, c, b});
      sof = 1'b0;
    end
    if (!chn) for (int i = 0; i < l2; i++) begin
      b = 8'($urandom);
      put_byte(a2 + i, b);
      exp_q.push_back({ls && (i == l2 - 1), sof, c, b});
      sof = 1'b0;
    end
    if (ls) st_q.push_back(st);
    wba_q.push_back(da);
    wbv_q.push_back(wb_exp(flg, ls ? st : 5'd0));
    if (flg[30]) exp_irq++;
  endtask

  task automatic wait_wb(input int target);
    int t = 0;
    while (wb_cnt < target && t < 20000) begin
      @(negedge clk);
      t++;
    end
    check(t < 20000, "R8 write-back count", 32'(wb_cnt), 32'(target));
    repeat (30) @(negedge clk);
  endtask

  task automatic verify(input string tag);
    check(exp_q.size() == 0, {tag, " R3 bytes left"}, 32'(exp_q.size()), 0);
    while (wba_q.size() > 0) begin
      int a;
      logic [31:0] v;
      a = wba_q.pop_front();
      v = wbv_q.pop_front();
      check(mem[a >> 2] === v, {tag, " R8 flags word"}, mem[a >> 2], v);
    end
    check(irq_cnt == exp_irq, {tag, " R9 irq count"}, 32'(irq_cnt), 32'(exp_irq));
  endtask

  // memory, sink and MAC models, driven away from the rising edge
  always @(negedge clk) begin
    if (rd_pend) begin
      mem_rvalid = 1'b1;
      mem_rdata  = mem[rd_addr[11:0]];
      rd_pend    = 1'b0;
    end else begin
      mem_rvalid = 1'b0;
    end
    mem_gnt = ($urandom % 4) != 0;
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        mem[mem_addr[11:0]] = mem_wdata;
        wb_cnt++;
      end else begin
        rd_pend = 1'b1;
        rd_addr = mem_addr;
      end
    end
    mac_done = 1'b0;
    if (mac_arm) begin
      if (mac_cnt == 0) begin
        mac_done   = 1'b1;
        mac_status = (st_q.size() > 0) ? st_q.pop_front() : 5'd0;
        mac_arm    = 1'b0;
      end else mac_cnt--;
    end
    tready = ($urandom % 3) != 0;
    if (tvalid && tready) begin
      logic [12:0] got, e;
      got = {tlast, tctrl, tdata};
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected byte", 32'(got), 0);
      end else begin
        e = exp_q.pop_front();
        check(got == e, "R3 R6 R7 byte {last,ctrl,data}", 32'(got), 32'(e));
      end
      if (tlast) begin
        mac_arm = 1'b1;
        mac_cnt = $urandom % 4;
      end
    end
    if (irq) irq_cnt++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int w0;
    void'($urandom(32'd4177));
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check(!tvalid && !mem_req && !irq, "R1 reset outputs", {29'd0, tvalid, mem_req, irq}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // ring of three: unaligned single buffer, two buffers, wrap at end
    add_desc(32'h100, 32'hD200_0000, 5, 32'h1003, 0, 0, 5'd0);
    add_desc(32'h120, 32'hB500_0010, 6, 32'h1100, 7, 32'h1182, 5'b00101);
    add_desc(32'h140, 32'hF220_0000, 4, 32'h1201, 3, 32'h1280, 5'b10000);
    base  = 32'h100;
    start = 1'b1;
    wait_wb(3);
    verify("ring");

    // suspended at base after wrap: nothing moves until poll
    w0 = wb_cnt;
    repeat (40) @(negedge clk);
    check(wb_cnt == w0, "R2 no write while suspended", 32'(wb_cnt), 32'(w0));
    add_desc(32'h100, 32'hB100_0000, 9, 32'h1300, 0, 0, 5'b01010);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 9, "R2 R10 no fetch before poll", 32'(exp_q.size()), 9);
    poll = 1'b1;
    @(negedge clk);
    poll = 1'b0;
    wait_wb(w0 + 1);
    verify("wrap R5 R10");

    // stop, reload base, chained pair with ignored buffer 2 size
    start = 1'b0;
    repeat (10) @(negedge clk);
    add_desc(32'h400, 32'h9210_0000, 10, 32'h1400, 32'h55, 32'h800, 5'd0);
    add_desc(32'h800, 32'hE000_0000, 3, 32'h1500, 2, 32'h1505, 5'b00010);
    base  = 32'h400;
    w0    = wb_cnt;
    start = 1'b1;
    wait_wb(w0 + 2);
    verify("chain R4 R11");

    // random single-frame descriptors on a fresh ring
    start = 1'b0;
    repeat (10) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      int l1, l2, a1;
      logic [31:0] f;
      l1 = $urandom % 20;
      l2 = $urandom % 20;
      if (l1 + l2 == 0) l1 = 1;
      a1 = 32'h2000 + i * 32'h100 + ($urandom % 4);
      f  = 32'hB000_0000 | ($urandom & 32'h4700_0010);
      if (i == 5) f[21] = 1'b1;
      add_desc(32'h600 + i * 32, f, l1, a1, l2, a1 + 32'h60 + ($urandom % 4), 5'($urandom));
    end
    base  = 32'h600;
    w0    = wb_cnt;
    start = 1'b1;
    wait_wb(w0 + 6);
    verify("random R3 R7 R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule